// File: doc/BRIEF.md
# Raw-Cell PDU Termination Tracker

This block follows raw ATM cells (no adaptation-layer trailer) through reassembly, one PDU per channel at a time. It reads only the cell header fields that matter for reassembly. A cell whose end-of-message bit is clear adds to the open PDU of its channel. A cell with that bit set closes the PDU. For each channel the block keeps a running byte count, a congestion flag and a loss-priority flag. When a PDU closes, it writes one status entry to a status stream.

A maximum PDU size is supplied as a plain configuration input. If a continuation cell would push the running total above that limit, the block writes an error entry marked as both a length error and an early discard. The channel then drops every further cell until the next end-of-message cell. That end-of-message cell only re-arms the channel and writes no entry.

The cell input and the status output are both valid/ready streams. An entry sits in a single output slot until the consumer takes it. A cell is accepted only in a cycle where that slot is empty or is being emptied. If the slot is full and `st_ready` is low, `cell_ready` drops. A cell that would produce an entry therefore never finds the slot occupied. The slot is loaded on the accepting clock edge, and the entry is visible on the status port from the following cycle. `max_len` must stay at least 48 below the largest value of the length field.

Top module: `aal0_pdu_tracker`

## Requirements
- R1: A cell with `cell_pti[0]` = 0 continues its channel's PDU and writes no entry. A cell with `cell_pti[0]` = 1 closes the PDU and writes exactly one entry, carrying its channel on `st_ch`.
- R2: `st_len` of a normal entry is 48 times the number of cells in the PDU, counting the closing cell.
- R3: `st_ci` is the OR of `cell_pti[1]` over every cell of the PDU.
- R4: `st_ci_last` is the `cell_pti[1]` value of the cell that produced the entry.
- R5: `st_lp` is the OR of `cell_clp` over every cell of the PDU.
- R6: Suppose a continuation cell arrives while the running total plus 48 exceeds `max_len`. It then writes an entry with `st_len_err` = 1 and `st_epd` = 1. The entry's length includes that cell, and its flags cover the cells so far.
- R7: After an R6 entry, later cells of that channel write no entry. The next end-of-message cell also writes none and returns the channel to empty. The following PDU starts from zero.
- R8: Each channel keeps its own state, so interleaved PDUs on different channels do not affect each other.
- R9: While `st_valid` = 1 and `st_ready` = 0, `cell_ready` is 0 and every status field holds its value.
- R10: After reset, `st_valid` is 0, `cell_ready` is 1 and all channels are empty.
- R11: Entries from an end-of-message cell have `st_len_err` = 0 and `st_epd` = 0.
- R12: An end-of-message cell is never checked against `max_len`. It closes the PDU normally even when the total exceeds the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| max_len | input | LEN_W | Largest allowed PDU size in bytes |
| cell_valid | input | 1 | Cell header present |
| cell_ready | output | 1 | Cell header accepted this cycle when valid |
| cell_ch | input | CH_W | Channel index of the cell |
| cell_pti | input | 2 | Bit 0: end of message; bit 1: congestion seen |
| cell_clp | input | 1 | Cell loss priority bit |
| st_valid | output | 1 | Status entry present |
| st_ready | input | 1 | Consumer takes the entry |
| st_ch | output | CH_W | Channel of the entry |
| st_len | output | LEN_W | PDU byte count |
| st_ci | output | 1 | Congestion seen on any cell |
| st_ci_last | output | 1 | Congestion on the last cell |
| st_lp | output | 1 | Loss priority seen on any cell |
| st_len_err | output | 1 | Length overrun |
| st_epd | output | 1 | Rest of PDU discarded |

## Verification
Two things can happen on one clock edge: the consumer drains the output slot, and a new closing cell refills it. The bench produces this by sending end-of-message cells back to back while `st_ready` toggles pseudo-randomly. A scoreboard then checks that every entry arrives once, in order, with the right fields. A second pairing happens when an overrun entry and the channel's switch into discard come from the same cell. That case is judged by checking that the channel's later cells produce nothing until its first clean PDU after recovery.

// File: rtl/aal0_term_pkg.sv
package aal0_term_pkg;
  localparam int unsigned CELL_PAYLOAD = 48;

  typedef struct packed {
    logic ci;
    logic ci_last;
    logic lp;
    logic len_err;
    logic epd;
  } pdu_flags_t;
endpackage

// File: rtl/aal0_chan_ctx.sv
module aal0_chan_ctx #(
  parameter int NUM_CH = 8,
  parameter int LEN_W  = 16,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CH_W-1:0]  rd_ch,
  output logic [LEN_W-1:0] rd_len,
  output logic             rd_ci,
  output logic             rd_lp,
  output logic             rd_disc,
  input  logic             wr_en,
  input  logic [CH_W-1:0]  wr_ch,
  input  logic [LEN_W-1:0] wr_len,
  input  logic             wr_ci,
  input  logic             wr_lp,
  input  logic             wr_disc
);
  logic [LEN_W-1:0] len_q  [NUM_CH];
  logic             ci_q   [NUM_CH];
  logic             lp_q   [NUM_CH];
  logic             disc_q [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        len_q[g]  <= '0;
        ci_q[g]   <= 1'b0;
        lp_q[g]   <= 1'b0;
        disc_q[g] <= 1'b0;
      end else if (wr_en && (int'(wr_ch) == g)) begin
        len_q[g]  <= wr_len;
        ci_q[g]   <= wr_ci;
        lp_q[g]   <= wr_lp;
        disc_q[g] <= wr_disc;
      end
    end
  end

  always_comb begin
    rd_len  = '0;
    rd_ci   = 1'b0;
    rd_lp   = 1'b0;
    rd_disc = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (int'(rd_ch) == i) begin
        rd_len  = len_q[i];
        rd_ci   = ci_q[i];
        rd_lp   = lp_q[i];
        rd_disc = disc_q[i];
      end
    end
  end
endmodule

// File: rtl/aal0_cell_eval.sv
module aal0_cell_eval
  import aal0_term_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic [LEN_W-1:0] cur_len,
  input  logic             cur_ci,
  input  logic             cur_lp,
  input  logic             cur_disc,
  input  logic             eom,
  input  logic             cong,
  input  logic             clp,
  input  logic [LEN_W-1:0] max_len,
  output logic [LEN_W-1:0] nxt_len,
  output logic             nxt_ci,
  output logic             nxt_lp,
  output logic             nxt_disc,
  output logic             emit,
  output logic [LEN_W-1:0] emit_len,
  output pdu_flags_t       emit_flags
);
  localparam logic [LEN_W:0] STEP = (LEN_W+1)'(CELL_PAYLOAD);

  logic [LEN_W:0] sum;
  logic           over;
  logic           ci_acc, lp_acc;

  assign sum    = {1'b0, cur_len} + STEP;
  assign over   = sum > {1'b0, max_len};
  assign ci_acc = cur_ci | cong;
  assign lp_acc = cur_lp | clp;

  always_comb begin
    nxt_len    = cur_len;
    nxt_ci     = cur_ci;
    nxt_lp     = cur_lp;
    nxt_disc   = cur_disc;
    emit       = 1'b0;
    emit_len   = sum[LEN_W-1:0];
    emit_flags = '{ci: ci_acc, ci_last: cong, lp: lp_acc, len_err: 1'b0, epd: 1'b0};
    if (cur_disc) begin
      if (eom) begin
        nxt_len  = '0;
        nxt_ci   = 1'b0;
        nxt_lp   = 1'b0;
        nxt_disc = 1'b0;
      end
    end else if (eom) begin
      emit    = 1'b1;
      nxt_len = '0;
      nxt_ci  = 1'b0;
      nxt_lp  = 1'b0;
    end else if (over) begin
      emit               = 1'b1;
      emit_flags.len_err = 1'b1;
      emit_flags.epd     = 1'b1;
      nxt_len            = '0;
      nxt_ci             = 1'b0;
      nxt_lp             = 1'b0;
      nxt_disc           = 1'b1;
    end else begin
      nxt_len = sum[LEN_W-1:0];
      nxt_ci  = ci_acc;
      nxt_lp  = lp_acc;
    end
  end
endmodule

// File: rtl/aal0_status_slot.sv
module aal0_status_slot
  import aal0_term_pkg::*;
#(
  parameter int CH_W  = 3,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CH_W-1:0]  load_ch,
  input  logic [LEN_W-1:0] load_len,
  input  pdu_flags_t       load_flags,
  output logic             can_take,
  output logic             st_valid,
  input  logic             st_ready,
  output logic [CH_W-1:0]  st_ch,
  output logic [LEN_W-1:0] st_len,
  output pdu_flags_t       st_flags
);
  assign can_take = !st_valid || st_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_valid <= 1'b0;
      st_ch    <= '0;
      st_len   <= '0;
      st_flags <= '0;
    end else if (load) begin
      st_valid <= 1'b1;
      st_ch    <= load_ch;
      st_len   <= load_len;
      st_flags <= load_flags;
    end else if (st_ready) begin
      st_valid <= 1'b0;
    end
  end

  // R9: a stalled entry keeps every field
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && !st_ready |=> st_valid && $stable(st_ch) && $stable(st_len) && $stable(st_flags));
  // R9: nothing loads into an occupied slot
  a_r9_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && !st_ready |-> !load);
endmodule

// File: rtl/aal0_pdu_tracker.sv
module aal0_pdu_tracker
  import aal0_term_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int LEN_W  = 16,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] max_len,
  input  logic             cell_valid,
  output logic             cell_ready,
  input  logic [CH_W-1:0]  cell_ch,
  input  logic [1:0]       cell_pti,
  input  logic             cell_clp,
  output logic             st_valid,
  input  logic             st_ready,
  output logic [CH_W-1:0]  st_ch,
  output logic [LEN_W-1:0] st_len,
  output logic             st_ci,
  output logic             st_ci_last,
  output logic             st_lp,
  output logic             st_len_err,
  output logic             st_epd
);
  logic             accept;
  logic [LEN_W-1:0] cur_len, nxt_len, emit_len;
  logic             cur_ci, cur_lp, cur_disc;
  logic             nxt_ci, nxt_lp, nxt_disc;
  logic             emit, can_take;
  pdu_flags_t       emit_flags, st_flags;

  assign cell_ready = can_take;
  assign accept     = cell_valid && cell_ready;

  aal0_chan_ctx #(.NUM_CH(NUM_CH), .LEN_W(LEN_W)) u_ctx (
    .clk(clk), .rst_n(rst_n),
    .rd_ch(cell_ch), .rd_len(cur_len), .rd_ci(cur_ci), .rd_lp(cur_lp), .rd_disc(cur_disc),
    .wr_en(accept), .wr_ch(cell_ch), .wr_len(nxt_len), .wr_ci(nxt_ci), .wr_lp(nxt_lp),
    .wr_disc(nxt_disc)
  );

  aal0_cell_eval #(.LEN_W(LEN_W)) u_eval (
    .cur_len(cur_len), .cur_ci(cur_ci), .cur_lp(cur_lp), .cur_disc(cur_disc),
    .eom(cell_pti[0]), .cong(cell_pti[1]), .clp(cell_clp), .max_len(max_len),
    .nxt_len(nxt_len), .nxt_ci(nxt_ci), .nxt_lp(nxt_lp), .nxt_disc(nxt_disc),
    .emit(emit), .emit_len(emit_len), .emit_flags(emit_flags)
  );

  aal0_status_slot #(.CH_W(CH_W), .LEN_W(LEN_W)) u_slot (
    .clk(clk), .rst_n(rst_n),
    .load(accept && emit), .load_ch(cell_ch), .load_len(emit_len), .load_flags(emit_flags),
    .can_take(can_take),
    .st_valid(st_valid), .st_ready(st_ready),
    .st_ch(st_ch), .st_len(st_len), .st_flags(st_flags)
  );

  assign st_ci      = st_flags.ci;
  assign st_ci_last = st_flags.ci_last;
  assign st_lp      = st_flags.lp;
  assign st_len_err = st_flags.len_err;
  assign st_epd     = st_flags.epd;

  // R1: a closing cell on a live channel yields an entry next cycle
  a_r1_close_emits: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cell_pti[0] && !cur_disc |=> st_valid);
  // R7: a cell on a discarding channel yields nothing
  a_r7_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cur_disc |=> !st_valid);
  // R6 / R11: the two error flags always travel together
  a_r6_err_pair: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> (st_len_err == st_epd));
  // R4: last-cell congestion is part of the OR
  a_r4_last_in_or: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && st_ci_last |-> st_ci);
  // R2: reported length is a whole number of cells
  a_r2_len_cells: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> (st_len != '0) && ((st_len % LEN_W'(CELL_PAYLOAD)) == '0));
endmodule

// File: tb/tb_aal0_pdu_tracker.sv
`timescale 1ns/1ps
module tb_aal0_pdu_tracker;
  localparam int NUM_CH = 8;
  localparam int LEN_W  = 16;
  localparam int CH_W   = 3;

  typedef struct packed {
    logic [CH_W-1:0]  ch;
    logic [LEN_W-1:0] len;
    logic ci, cil, lp, err, epd;
  } ent_t;

  logic clk = 0, rst_n = 0;
  logic [LEN_W-1:0] max_len = 16'd480;
  logic cell_valid = 0, cell_clp = 0;
  logic [CH_W-1:0] cell_ch = '0;
  logic [1:0] cell_pti = '0;
  logic cell_ready, st_valid, st_ready;
  logic [CH_W-1:0] st_ch;
  logic [LEN_W-1:0] st_len;
  logic st_ci, st_ci_last, st_lp, st_len_err, st_epd;

  int checks = 0, errors = 0;
  int rdy_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit done = 0;

  ent_t exp_q[$];
  logic [LEN_W-1:0] m_len [NUM_CH];
  logic m_ci [NUM_CH], m_lp [NUM_CH], m_disc [NUM_CH];

  aal0_pdu_tracker #(.NUM_CH(NUM_CH), .LEN_W(LEN_W)) dut (
    .clk(clk), .rst_n(rst_n), .max_len(max_len),
    .cell_valid(cell_valid), .cell_ready(cell_ready), .cell_ch(cell_ch),
    .cell_pti(cell_pti), .cell_clp(cell_clp),
    .st_valid(st_valid), .st_ready(st_ready), .st_ch(st_ch), .st_len(st_len),
    .st_ci(st_ci), .st_ci_last(st_ci_last), .st_lp(st_lp),
    .st_len_err(st_len_err), .st_epd(st_epd)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (rdy_mode)
      0: st_ready = 1'b1;
      1: st_ready = lfsr[0];
      default: st_ready = 1'b0;
    endcase
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // monitor: pops the scoreboard on every handshake
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && st_valid && st_ready) begin
        if (exp_q.size() == 0) begin
          chk(0, "R1/R7 unexpected entry on channel", int'(st_ch), -1);
        end else begin
          ent_t e;
          e = exp_q.pop_front();
          chk(st_ch == e.ch, "R1/R8 st_ch", int'(st_ch), int'(e.ch));
          chk(st_len == e.len, "R2/R6/R12 st_len", int'(st_len), int'(e.len));
          chk(st_ci == e.ci, "R3 st_ci", int'(st_ci), int'(e.ci));
          chk(st_ci_last == e.cil, "R4 st_ci_last", int'(st_ci_last), int'(e.cil));
          chk(st_lp == e.lp, "R5 st_lp", int'(st_lp), int'(e.lp));
          chk(st_len_err == e.err, "R6/R11 st_len_err", int'(st_len_err), int'(e.err));
          chk(st_epd == e.epd, "R6/R11 st_epd", int'(st_epd), int'(e.epd));
        end
      end
    end
  end

  // driver: call right after a falling edge; returns at a falling edge
  task automatic send(input int ch, input bit eom, input bit cong, input bit clp);
    logic [LEN_W:0] sum;
    cell_valid = 1; cell_ch = CH_W'(ch); cell_pti = {cong, eom}; cell_clp = clp;
    #1;
    while (!cell_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    sum = {1'b0, m_len[ch]} + 17'd48;
    if (m_disc[ch]) begin
      if (eom) begin m_disc[ch] = 0; m_len[ch] = 0; m_ci[ch] = 0; m_lp[ch] = 0; end
    end else if (eom) begin
      exp_q.push_back('{CH_W'(ch), sum[LEN_W-1:0], m_ci[ch] | cong, cong, m_lp[ch] | clp, 1'b0, 1'b0});
      m_len[ch] = 0; m_ci[ch] = 0; m_lp[ch] = 0;
    end else if (sum > {1'b0, max_len}) begin
      exp_q.push_back('{CH_W'(ch), sum[LEN_W-1:0], m_ci[ch] | cong, cong, m_lp[ch] | clp, 1'b1, 1'b1});
      m_len[ch] = 0; m_ci[ch] = 0; m_lp[ch] = 0; m_disc[ch] = 1;
    end else begin
      m_len[ch] = sum[LEN_W-1:0]; m_ci[ch] |= cong; m_lp[ch] |= clp;
    end
    @(negedge clk);
    cell_valid = 0;
  endtask

  task automatic drain();
    int n = 0;
    while ((exp_q.size() != 0 || st_valid) && n < 200) begin @(negedge clk); n++; end
  endtask

  initial begin
    for (int i = 0; i < NUM_CH; i++) begin m_len[i] = 0; m_ci[i] = 0; m_lp[i] = 0; m_disc[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10: reset state
    chk(st_valid == 0, "R10 st_valid after reset", int'(st_valid), 0);
    chk(cell_ready == 1, "R10 cell_ready after reset", int'(cell_ready), 1);

    // R1 R2 R3 R4 R5: three-cell PDU, congestion mid-PDU only, CLP on one cell
    send(0, 0, 0, 0); send(0, 0, 1, 1); send(0, 1, 0, 0);
    // R4: single closing cell with congestion
    send(1, 1, 1, 0);
    // R8: interleaved channels
    send(2, 0, 0, 1); send(3, 0, 1, 0); send(2, 0, 0, 0); send(3, 1, 0, 0); send(2, 1, 1, 0);
    drain();

    // R6 R7: overrun on channel 4, discard, recovery
    for (int i = 0; i < 11; i++) send(4, 0, 0, 0);
    send(4, 0, 1, 1); send(4, 0, 0, 0); send(4, 1, 0, 0);
    drain();
    chk(st_valid == 0, "R7 no entry while discarding", int'(st_valid), 0);
    send(4, 0, 0, 0); send(4, 1, 0, 0);
    // R12: closing cell past the limit completes normally
    for (int i = 0; i < 10; i++) send(5, 0, 0, 0);
    send(5, 1, 0, 1);
    drain();

    // R9: stalled slot blocks input and holds fields
    rdy_mode = 2;
    @(negedge clk);
    send(6, 1, 1, 1);
    cell_valid = 1; cell_ch = 3'd7; cell_pti = 2'b01; cell_clp = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(cell_ready == 0, "R9 cell_ready while stalled", int'(cell_ready), 0);
      chk(st_valid == 1 && st_ch == 3'd6 && st_len == 16'd48, "R9 held entry", int'(st_len), 48);
    end
    cell_valid = 0;
    rdy_mode = 0;
    drain();

    // R8 R1: random traffic with random back-pressure, back-to-back closings
    rdy_mode = 1;
    max_len = 16'd240;
    @(negedge clk);
    for (int i = 0; i < 400; i++)
      send($urandom_range(0, NUM_CH - 1), ($urandom_range(0, 3) == 0), $urandom_range(0, 1) == 1,
           ($urandom_range(0, 5) == 0));
    for (int i = 0; i < 30; i++) send(i % NUM_CH, 1, 0, 0);
    rdy_mode = 0;
    drain();
    chk(exp_q.size() == 0, "R1 all expected entries seen", exp_q.size(), 0);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule